// File: doc/BRIEF.md
# Queued Input Capture Channel Unit

This block holds eight input capture channels that record the value of a free-running timer when a programmed edge arrives on their pins. The four lower channels each own a second holding register behind the capture register. In queue mode, each new capture pushes the previous capture value into the holding register. In latch mode, a strobe copies all lower capture values into their holding registers at once. The four upper channels are capture-only. Each upper channel can be told to follow the edge detector of its lower partner instead of its own pin.

A small register bus sets the edge type per channel, the queue and flag options and a per-channel no-overwrite guard. The bus also reads every capture and holding register. Reading a holding register marks that channel's queue empty. A flag mode lets one flag cover a pair of queued captures instead of one per edge. Flags are cleared by writing ones over the bus. The mode register can be written only once unless the special-mode input is high.

Top module: `icq_top`

## Requirements
- R1: After reset the mode register (address 0), the flags (address 3), all capture outputs and all holding outputs read zero.
- R2: With `special_mode` low, only the first write to address 0 after reset takes effect and later writes leave it unchanged. With `special_mode` high, address 0 may be written any number of times. Mode register bits: [0] latch mode, [1] buffer enable, [2] reads zero, [3] flag mode, [4+k] share channel k onto channel k+4.
- R3: Address 1 bits [2c+1:2c] select the edge of channel c: 00 none, 01 rising, 10 falling, 11 either. A capture loads the `timer` value present at the clock edge where the pin change is first seen.
- R4: With buffer enable 0, every selected edge loads the capture register, sets the channel flag (address 3 bit c) and leaves the holding register unchanged.
- R5: In queue mode (buffer enable 1, latch mode 0) with the channel's no-overwrite bit (address 2 bit c) clear, each edge moves the capture value into the holding register and loads the capture register with the timer.
- R6: In queue mode with no-overwrite set, starting empty: the first edge loads only the capture register, the second edge shifts and loads as in R5, and further edges change nothing while both registers are full.
- R7: A bus read of holding register k (address 12+k) marks channel k's queue empty. An edge in the same cycle acts on the emptied queue, so it loads only the capture register.
- R8: With flag mode 1 in queue mode, a channel flag is raised only by an edge that moves data into the holding register. Outside queue mode, flag mode has no effect and every capture raises the flag.
- R9: With share bit k set, edges seen by channel k's detector also capture on channel k+4, and channel k+4's own pin is ignored.
- R10: In latch mode (buffer enable 1, latch mode 1), edges load only the capture registers. A high `hold_latch` copies each lower capture register into its holding register.
- R11: Writing 1 to flag bit c clears it, and writing 0 leaves it unchanged. A flag set in the same cycle as a clearing write ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| special_mode | input | 1 | High allows repeated writes of the mode register |
| pins | input | 8 | Capture inputs, one per channel, synchronous to clk |
| timer | input | 16 | Free-running timer value |
| hold_latch | input | 1 | In latch mode, copies lower capture values to holding registers |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| cap_out | output | 128 | Capture registers, channel c at bits [16c+15:16c] |
| hold_out | output | 64 | Holding registers, channel k at bits [16k+15:16k] |
| flags | output | 8 | Per-channel capture flags |

## Verification
Two pairs of functions can fall in the same cycle. In the first pair, a holding-register read that empties the queue meets a new edge on the same channel. The bench issues the read in the cycle where the pin rises. It expects the capture register to take the new timer value while the holding register keeps its old contents. A second edge must then shift normally, which shows the queue was treated as empty. In the second pair, a flag-clearing write meets a capture on the same channel, and the flag must read set afterwards.

// File: rtl/icq_pkg.sv
package icq_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  // mode register bit positions
  localparam int MB_LATCH = 0;
  localparam int MB_BUFEN = 1;
  localparam int MB_FMODE = 3;
  localparam int MB_SHARE = 4;

  // register addresses
  localparam int A_MODE  = 0;
  localparam int A_EDGE  = 1;
  localparam int A_GUARD = 2;
  localparam int A_FLAGS = 3;
  localparam int A_CAP0  = 4;

  function automatic logic edge_hit(input logic [1:0] sel, input logic prev, input logic cur);
    case (edge_sel_e'(sel))
      EDGE_RISE: edge_hit = !prev && cur;
      EDGE_FALL: edge_hit = prev && !cur;
      EDGE_ANY:  edge_hit = prev != cur;
      default:   edge_hit = 1'b0;
    endcase
  endfunction

  function automatic logic queue_on(input logic bufen, input logic latch);
    queue_on = bufen && !latch;
  endfunction

endpackage

// File: rtl/icq_edge.sv
module icq_edge
  import icq_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   pins,
  input  logic [2*N-1:0] sel,
  output logic [N-1:0]   hit
);
  logic [N-1:0] prev;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= '0;
    else        prev <= pins;
  end

  for (genvar i = 0; i < N; i++) begin : g_det
    assign hit[i] = edge_hit(sel[2*i +: 2], prev[i], pins[i]);
  end
endmodule

// File: rtl/icq_lane.sv
module icq_lane #(
  parameter int TW       = 16,
  parameter bit HAS_HOLD = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt,
  input  logic [TW-1:0] timer,
  input  logic          queue,
  input  logic          latch_on,
  input  logic          fmode,
  input  logic          guard,
  input  logic          hold_clr,
  input  logic          latch_stb,
  output logic [TW-1:0] cap,
  output logic [TW-1:0] hold,
  output logic          flag_set
);
  logic          q_act, cap_full, hold_full, cf_e, hf_e;
  logic          n_cf, n_hf, hold_load;
  logic [TW-1:0] n_cap;

  assign q_act = HAS_HOLD ? queue : 1'b0;
  assign cf_e  = cap_full  && !hold_clr;
  assign hf_e  = hold_full && !hold_clr;

  always_comb begin
    n_cap     = cap;
    n_cf      = 1'b0;
    n_hf      = 1'b0;
    hold_load = 1'b0;
    flag_set  = 1'b0;
    if (q_act) begin
      n_cf = cf_e;
      n_hf = hf_e;
      if (evt) begin
        if (guard && cf_e && hf_e) begin
          n_cap = cap;
        end else if (guard && !cf_e) begin
          n_cap    = timer;
          n_cf     = 1'b1;
          flag_set = !fmode;
        end else begin
          hold_load = 1'b1;
          n_cap     = timer;
          n_cf      = 1'b1;
          n_hf      = 1'b1;
          flag_set  = 1'b1;
        end
      end
    end else begin
      if (evt) begin
        n_cap    = timer;
        flag_set = 1'b1;
      end
      hold_load = HAS_HOLD && latch_on && latch_stb;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap       <= '0;
      cap_full  <= 1'b0;
      hold_full <= 1'b0;
    end else begin
      cap       <= n_cap;
      cap_full  <= n_cf;
      hold_full <= n_hf;
    end
  end

  if (HAS_HOLD) begin : g_hold
    always_ff @(posedge clk) begin
      if (!rst_n)         hold <= '0;
      else if (hold_load) hold <= cap;
    end

    AST_QUEUE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      (queue && evt && !guard) |=> (hold == $past(cap)) && (cap == $past(timer))); // R5
    AST_FULL_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (queue && guard && evt && cap_full && hold_full && !hold_clr) |=> $stable(cap) && $stable(hold)); // R6
    AST_QFLAG_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (queue && fmode && flag_set) |=> (hold == $past(cap))); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!queue && !latch_on) |=> $stable(hold)); // R4
  end else begin : g_nohold
    assign hold = '0;
  end
endmodule

// File: rtl/icq_top.sv
module icq_top
  import icq_pkg::*;
#(
  parameter int NPAIR = 4,
  parameter int TW    = 16,
  parameter int BW    = 16,
  parameter int AW    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 special_mode,
  input  logic [2*NPAIR-1:0]   pins,
  input  logic [TW-1:0]        timer,
  input  logic                 hold_latch,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [AW-1:0]        bus_addr,
  input  logic [BW-1:0]        bus_wdata,
  output logic [BW-1:0]        bus_rdata,
  output logic [2*NPAIR*TW-1:0] cap_out,
  output logic [NPAIR*TW-1:0]  hold_out,
  output logic [2*NPAIR-1:0]   flags
);
  localparam int NCH    = 2 * NPAIR;
  localparam int CW     = MB_SHARE + NPAIR;
  localparam int A_HOLD = A_CAP0 + NCH;

  logic [CW-1:0]    mode_q;
  logic             locked;
  logic [2*NCH-1:0] edge_q;
  logic [NCH-1:0]   guard_q;
  logic [NCH-1:0]   hit, evt, set_w;
  logic [NPAIR-1:0] hclr;
  logic [TW-1:0]    cap_w  [NCH];
  logic [TW-1:0]    hold_w [NCH];
  logic             wr_en, rd_en, mode_wr, flag_wr, qmode, lmode;

  assign wr_en   = bus_sel && bus_wr;
  assign rd_en   = bus_sel && !bus_wr;
  assign mode_wr = wr_en && (int'(bus_addr) == A_MODE) && (special_mode || !locked);
  assign flag_wr = wr_en && (int'(bus_addr) == A_FLAGS);
  assign qmode   = queue_on(mode_q[MB_BUFEN], mode_q[MB_LATCH]);
  assign lmode   = mode_q[MB_BUFEN] && mode_q[MB_LATCH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      locked  <= 1'b0;
      edge_q  <= '0;
      guard_q <= '0;
      flags   <= '0;
    end else begin
      if (mode_wr) begin
        mode_q         <= bus_wdata[CW-1:0];
        mode_q[2]      <= 1'b0;
        if (!special_mode) locked <= 1'b1;
      end
      if (wr_en && int'(bus_addr) == A_EDGE)  edge_q  <= bus_wdata[2*NCH-1:0];
      if (wr_en && int'(bus_addr) == A_GUARD) guard_q <= bus_wdata[NCH-1:0];
      flags <= (flags & ~(flag_wr ? bus_wdata[NCH-1:0] : '0)) | set_w;
    end
  end

  icq_edge #(.N(NCH)) u_edge (
    .clk(clk), .rst_n(rst_n), .pins(pins), .sel(edge_q), .hit(hit)
  );

  for (genvar k = 0; k < NPAIR; k++) begin : g_route
    assign evt[k]         = hit[k];
    assign evt[k + NPAIR] = mode_q[MB_SHARE + k] ? hit[k] : hit[k + NPAIR];
    assign hclr[k]        = rd_en && (int'(bus_addr) == A_HOLD + k);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    localparam bit LOW = (c < NPAIR);
    icq_lane #(.TW(TW), .HAS_HOLD(LOW)) u_lane (
      .clk(clk), .rst_n(rst_n), .evt(evt[c]), .timer(timer),
      .queue(LOW ? qmode : 1'b0), .latch_on(LOW ? lmode : 1'b0),
      .fmode(mode_q[MB_FMODE]), .guard(guard_q[c]),
      .hold_clr(LOW ? hclr[c % NPAIR] : 1'b0), .latch_stb(hold_latch),
      .cap(cap_w[c]), .hold(hold_w[c]), .flag_set(set_w[c])
    );
    assign cap_out[c*TW +: TW] = cap_w[c];
    if (LOW) begin : g_hout
      assign hold_out[c*TW +: TW] = hold_w[c];
    end

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr && bus_wdata[c] && !set_w[c]) |=> !flags[c]); // R11
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_w[c] |=> flags[c]); // R11
  end

  always_comb begin
    bus_rdata = '0;
    if (int'(bus_addr) == A_MODE)       bus_rdata = BW'(mode_q);
    else if (int'(bus_addr) == A_EDGE)  bus_rdata = BW'(edge_q);
    else if (int'(bus_addr) == A_GUARD) bus_rdata = BW'(guard_q);
    else if (int'(bus_addr) == A_FLAGS) bus_rdata = BW'(flags);
    else begin
      for (int i = 0; i < NCH; i++)
        if (int'(bus_addr) == A_CAP0 + i) bus_rdata = BW'(cap_w[i]);
      for (int i = 0; i < NPAIR; i++)
        if (int'(bus_addr) == A_HOLD + i) bus_rdata = BW'(hold_w[i]);
    end
  end

  AST_MODE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !special_mode) |=> $stable(mode_q)); // R2
  AST_SHARE_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[MB_SHARE] && hit[0]) |=> (cap_w[NPAIR] == cap_w[0])); // R9
endmodule

// File: tb/sim_icq_top.sv
`timescale 1ns/1ps
module sim_icq_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         special_mode = 1'b1;
  logic [7:0]   pins = '0;
  logic [15:0]  timer = '0;
  logic         hold_latch = 1'b0;
  logic         bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]   bus_addr = '0;
  logic [15:0]  bus_wdata = '0;
  logic [15:0]  bus_rdata;
  logic [127:0] cap_out;
  logic [63:0]  hold_out;
  logic [7:0]   flags;
  int checks = 0, errors = 0;
  logic [15:0]  rv;

  always #4 clk = ~clk;

  icq_top u0 (.clk(clk), .rst_n(rst_n), .special_mode(special_mode), .pins(pins),
    .timer(timer), .hold_latch(hold_latch), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_out(cap_out), .hold_out(hold_out), .flags(flags));

  // {pin0, timer, expected capture 0, expected flag 0}, channel 0 rising, buffer off
  localparam logic [33:0] VEC [6] = '{
    {1'b1, 16'h0100, 16'h0100, 1'b1},
    {1'b0, 16'h0200, 16'h0100, 1'b0},
    {1'b1, 16'h0300, 16'h0300, 1'b1},
    {1'b1, 16'h0400, 16'h0300, 1'b0},
    {1'b0, 16'h0500, 16'h0300, 1'b0},
    {1'b1, 16'h0600, 16'h0600, 1'b1}
  };

  function automatic logic [15:0] capv(input int c); return cap_out[c*16 +: 16]; endfunction
  function automatic logic [15:0] holdv(input int c); return hold_out[c*16 +: 16]; endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic rise(input int ch, input logic [15:0] t);
    @(negedge clk); pins[ch] = 0;
    @(negedge clk); pins[ch] = 1; timer = t;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 cap", cap_out, 0);
    check("R1 hold", hold_out, 0);
    check("R1 flags", flags, 0);
    rd(0, rv); check("R1 mode", rv, 0);

    // R3/R4 vector walk
    wr(1, 16'h5555); wr(0, 16'h0000);
    foreach (VEC[i]) begin
      @(negedge clk); pins[0] = VEC[i][33]; timer = VEC[i][32:17];
      @(negedge clk);
      check("R4 cap0", capv(0), VEC[i][16:1]);
      check("R3 flag0", flags[0], VEC[i][0]);
      check("R4 hold0", holdv(0), 0);
      wr(3, 16'h00FF);
    end
    // R3 falling and disabled codes
    wr(1, 16'h5556);
    @(negedge clk); pins[0] = 0; timer = 16'h0700;
    @(negedge clk); check("R3 falling", capv(0), 16'h0700);
    wr(1, 16'h5554);
    @(negedge clk); pins[0] = 1; timer = 16'h0800;
    @(negedge clk); pins[0] = 0; timer = 16'h0900;
    @(negedge clk); check("R3 none", capv(0), 16'h0700);
    wr(1, 16'h5555);

    // R5 queue, no guard
    wr(0, 16'h0002);
    rise(0, 16'h1000);
    check("R5 cap", capv(0), 16'h1000); check("R5 hold", holdv(0), 16'h0700);
    rise(0, 16'h1100);
    check("R5 cap b", capv(0), 16'h1100); check("R5 hold b", holdv(0), 16'h1000);

    // R6/R8 queue, guard, flag mode
    wr(0, 16'h000A); wr(2, 16'h0001);
    rd(12, rv); wr(3, 16'h00FF);
    rise(0, 16'h2000);
    check("R6 first cap", capv(0), 16'h2000); check("R6 first hold", holdv(0), 16'h1000);
    check("R8 no flag", flags[0], 0);
    rise(0, 16'h2100);
    check("R6 shift cap", capv(0), 16'h2100); check("R6 shift hold", holdv(0), 16'h2000);
    check("R8 flag", flags[0], 1);
    rise(0, 16'h2200);
    check("R6 full cap", capv(0), 16'h2100); check("R6 full hold", holdv(0), 16'h2000);
    // R7 read and edge together
    @(negedge clk); pins[0] = 0;
    @(negedge clk); pins[0] = 1; timer = 16'h2300; bus_sel = 1; bus_wr = 0; bus_addr = 12;
    @(negedge clk); bus_sel = 0;
    check("R7 cap", capv(0), 16'h2300); check("R7 hold", holdv(0), 16'h2000);
    rise(0, 16'h2400);
    check("R7 next cap", capv(0), 16'h2400); check("R7 next hold", holdv(0), 16'h2300);

    // R11 clear and clear-vs-set
    rise(4, 16'h3000);
    check("R11 set", flags[4], 1);
    wr(3, 16'h0010);
    check("R11 clear", flags[4], 0); check("R11 other", flags[0], 1);
    @(negedge clk); pins[4] = 0;
    @(negedge clk); pins[4] = 1; timer = 16'h3100; bus_sel = 1; bus_wr = 1; bus_addr = 3; bus_wdata = 16'h0010;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
    check("R11 set wins", flags[4], 1); check("R11 cap4", capv(4), 16'h3100);

    // R9 sharing
    wr(0, 16'h0010);
    rise(0, 16'h4000);
    check("R9 cap0", capv(0), 16'h4000); check("R9 cap4", capv(4), 16'h4000);
    rise(4, 16'h4100);
    check("R9 own pin ignored", capv(4), 16'h4000);

    // R8 flag mode outside queue
    wr(0, 16'h0009); wr(3, 16'h00FF);
    rise(2, 16'h6000);
    check("R8 nonqueue flag", flags[2], 1); check("R8 cap2", capv(2), 16'h6000);

    // R10 latch mode
    wr(0, 16'h0003);
    rise(1, 16'h5000);
    check("R10 cap1", capv(1), 16'h5000); check("R10 hold1 idle", holdv(1), 0);
    @(negedge clk); hold_latch = 1;
    @(negedge clk); hold_latch = 0;
    check("R10 hold1", holdv(1), 16'h5000); check("R10 hold0", holdv(0), 16'h4000);

    // R2 write-once
    special_mode = 0; rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    wr(0, 16'h0002); wr(0, 16'h000A);
    rd(0, rv); check("R2 locked", rv, 16'h0002);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule